// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a clocked host to an asynchronous 16-bit static RAM that has two byte lanes. The host offers one word access at a time through a valid/ready handshake. Each request carries a read/write flag, an 18-bit word address, 16 bits of write data and a 2-bit lane mask. The controller turns each request into a strobe sequence on the memory pins. Read data comes back with a one-cycle valid strobe.

All memory timing is given as nanosecond parameters plus the clock period. The controller converts each value to a whole number of cycles by rounding up. A write ends with write enable rising while every other signal is held. A read is followed by idle cycles, so the memory's outputs have floated before the controller drives the data bus again. A request whose lane mask is zero completes without touching the memory.

Top module: `sram_bus_ctrl`

## Requirements
- R1: A write holds chip enable and write enable low together. Mask bit 0 (lane enable `mem_be_n[0]` low) stores data bits 7:0, and mask bit 1 (`mem_be_n[1]` low) stores bits 15:8, at `mem_addr`. A lane whose mask bit is 0 stays unchanged.
- R2: A read holds chip enable and output enable low, with write enable high and the data bus not driven. A lane whose mask bit is 1 returns the memory's byte. A lane whose mask bit is 0 returns zero.
- R3: Whenever the controller is ready, chip enable, write enable, output enable and both lane enables are high and the data bus is not driven.
- R4: Write enable stays low for WE = max(ceil(tPWE/T), ceil(tSD/T), ceil(tAW/T)-1, 1) cycles. A write keeps ready low for 1 + WE + max(1, ceil(tWC/T)-WE-1) cycles. For the fast grade at T = 4 ns this is 10 and 14.
- R5: Output enable stays low for RD = ceil(tAA/T) cycles. It is followed by TA = max(1, ceil(tHZOE/T)) deselected cycles, and ready stays low for RD+TA cycles. At 4 ns this is 14 and 18.
- R6: A write ends with write enable rising while chip enable, the lane enables, the address and the driven data stay unchanged. The data bus is driven in every cycle of a write and is released at least one cycle after write enable rises.
- R7: `rsp_valid` is high for exactly one cycle, the one after the last output-enable-low cycle, with `rsp_rdata` valid in that cycle. It never rises for writes or no-ops.
- R8: Ready is high only when no access is in progress. A request is taken on a clock edge with `req_valid` and `req_ready` both high, and its fields are captured at that edge.
- R9: A request with mask 00 is a no-op. The memory pins stay deselected, ready stays high in the next cycle, and no response is produced.
- R10: The controller never drives the data bus while the memory may still drive it, that is, during output-enable-low cycles or within ceil(tHZOE/T) cycles after output enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = lower byte |
| mem_addr | output | 18 | Memory address |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 16 | Data bus as seen from memory |

## Verification
The hardest case to reach is a controller write that starts right after a read, while the memory may still be driving the bus in its float window. The bench issues each new request at the first cycle in which ready is high, so read-then-write pairs come back to back. Its memory model keeps driving for ceil(tHZOE/T) cycles after output enable rises, and any overlap with controller drive is flagged. Mixed lane masks, zero masks and a small address pool, which includes both ends of the address range, make partial-lane overwrites and readbacks of the same word frequent.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RACC   = 3'd4,
    ST_RTURN  = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WE_CYC   = 4,
  parameter int HOLD_CYC = 1,
  parameter int RD_CYC   = 6,
  parameter int TA_CYC   = 2,
  parameter int CNT_W    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_write,
  output seq_state_t state_q,
  output seq_state_t state_d,
  output logic       last_read
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign last_read = (state_q == ST_RACC) && cnt_zero;
  assign cnt_en    = (state_q != ST_IDLE) || start;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = start_write ? ST_WSETUP : ST_RACC;
          cnt_d   = start_write ? '0 : CNT_W'(RD_CYC - 1);
        end
      end
      ST_WSETUP: begin
        state_d = ST_WPULSE;
        cnt_d   = CNT_W'(WE_CYC - 1);
      end
      ST_WPULSE: begin
        if (cnt_zero) begin
          state_d = ST_WHOLD;
          cnt_d   = CNT_W'(HOLD_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WHOLD: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_RACC: begin
        if (cnt_zero) begin
          state_d = ST_RTURN;
          cnt_d   = CNT_W'(TA_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RTURN: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // A write always passes from the setup cycle into the pulse.
  AST_SETUP_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WSETUP) |=> (state_q == ST_WPULSE)) else $error("setup"); // R4
  // A read access is always followed by the turnaround phase.
  AST_READ_THEN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    last_read |=> (state_q == ST_RTURN)) else $error("turn"); // R5

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_t       state_d,
  input  logic [LANES-1:0] mask_d,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [LANES-1:0] be_n,
  output logic             dq_oe
);

  strobe_t          strb_d, strb_q;
  logic [LANES-1:0] be_d, be_q;

  always_comb begin
    strb_d = STROBE_IDLE;
    be_d   = '1;
    case (state_d)
      ST_WSETUP, ST_WHOLD: begin
        strb_d.ce_n  = 1'b0;
        strb_d.dq_oe = 1'b1;
        be_d         = ~mask_d;
      end
      ST_WPULSE: begin
        strb_d.ce_n  = 1'b0;
        strb_d.we_n  = 1'b0;
        strb_d.dq_oe = 1'b1;
        be_d         = ~mask_d;
      end
      ST_RACC: begin
        strb_d.ce_n = 1'b0;
        strb_d.oe_n = 1'b0;
        be_d        = ~mask_d;
      end
      default: begin
        strb_d = STROBE_IDLE;
        be_d   = '1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= STROBE_IDLE;
      be_q   <= '1;
    end else begin
      strb_q <= strb_d;
      be_q   <= be_d;
    end
  end

  assign ce_n  = strb_q.ce_n;
  assign we_n  = strb_q.we_n;
  assign oe_n  = strb_q.oe_n;
  assign dq_oe = strb_q.dq_oe;
  assign be_n  = be_q;

  AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && dq_oe && oe_n && (be_n != '1))) else $error("we"); // R1
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !ce_n && !dq_oe)) else $error("oe"); // R2
  AST_WE_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (!ce_n && dq_oe && $stable(be_n))) else $error("rise"); // R6
  AST_RELEASE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> $past(we_n)) else $error("release"); // R6

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int LW = DATA_W / LANES;

  logic [LW-1:0] lane_q [LANES];
  logic          valid_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[l] <= '0;
      end else if (capture) begin
        lane_q[l] <= lane_en[l] ? dq_in[l*LW +: LW] : '0;
      end
    end
    assign rsp_rdata[l*LW +: LW] = lane_q[l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= capture;
  end

  assign rsp_valid = valid_q;

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid) else $error("rsp"); // R7

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 10,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 40,
  parameter int T_SD_NS   = 25,
  parameter int T_AW_NS   = 40,
  parameter int T_AA_NS   = 55,
  parameter int T_HZOE_NS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W/8-1:0]  req_mask,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 mem_ce_n,
  output logic                 mem_we_n,
  output logic                 mem_oe_n,
  output logic [DATA_W/8-1:0]  mem_be_n,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_dq_out,
  output logic                 mem_dq_oe,
  input  logic [DATA_W-1:0]    mem_dq_in
);

  localparam int LANES    = DATA_W / 8;
  localparam int WE_CYC   = imax(1, imax(imax(cdiv(T_PWE_NS, CLK_NS), cdiv(T_SD_NS, CLK_NS)),
                                         cdiv(T_AW_NS, CLK_NS) - 1));
  localparam int HOLD_CYC = imax(1, cdiv(T_WC_NS, CLK_NS) - WE_CYC - 1);
  localparam int RD_CYC   = imax(1, cdiv(T_AA_NS, CLK_NS));
  localparam int TA_CYC   = imax(1, cdiv(T_HZOE_NS, CLK_NS));
  localparam int MAX_CYC  = imax(imax(WE_CYC, HOLD_CYC), imax(RD_CYC, TA_CYC));
  localparam int CNT_W    = imax(1, $clog2(MAX_CYC + 1));

  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_t state_q, state_d;
  logic       accept, start, last_read;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign start     = accept && (req_mask != '0);

  // Request registers, loaded only when a real access begins.
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [LANES-1:0]  mask_next;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  assign mask_next  = start ? req_mask : mask_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  sram_seq_fsm #(
    .WE_CYC  (WE_CYC),
    .HOLD_CYC(HOLD_CYC),
    .RD_CYC  (RD_CYC),
    .TA_CYC  (TA_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .start_write(req_write),
    .state_q    (state_q),
    .state_d    (state_d),
    .last_read  (last_read)
  );

  sram_pin_drv #(
    .LANES(LANES)
  ) u_pins (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .state_d(state_d),
    .mask_d (mask_next),
    .ce_n   (mem_ce_n),
    .we_n   (mem_we_n),
    .oe_n   (mem_oe_n),
    .be_n   (mem_be_n),
    .dq_oe  (mem_dq_oe)
  );

  sram_rd_capture #(
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .capture  (last_read),
    .lane_en  (mask_q),
    .dq_in    (mem_dq_in),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && (mem_be_n == '1)))
    else $error("idle"); // R3
  AST_NOOP_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && (req_mask == '0)) |=> (req_ready && mem_ce_n)) else $error("noop"); // R9
  AST_TURN_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(mem_oe_n) |-> (!req_ready && !mem_dq_oe)) else $error("turn"); // R10
  AST_BUSY_NO_RESPONSE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mem_we_n |-> !rsp_valid) else $error("wrsp"); // R7

endmodule

// File: tb/tb_sram_bus_ctrl.sv
module tb_sram_bus_ctrl;

  localparam int CLK_NS = 4;

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected cycle counts from the requirement formulas (fast grade).
  localparam int E_WE   = imax(1, imax(imax(cdiv(40, CLK_NS), cdiv(25, CLK_NS)), cdiv(40, CLK_NS) - 1));
  localparam int E_WR   = 1 + E_WE + imax(1, cdiv(55, CLK_NS) - E_WE - 1);
  localparam int E_RD   = imax(1, cdiv(55, CLK_NS));
  localparam int E_TA   = imax(1, cdiv(16, CLK_NS));
  localparam int HZ_CYC = cdiv(16, CLK_NS);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [17:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;

  always #2 clk = ~clk;

  sram_bus_ctrl #(.CLK_NS(CLK_NS)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem   [logic [17:0]];
  logic [15:0] refm  [logic [17:0]];
  bit          armed = 1'b0;
  int          wr_evt = 0;
  int          nodrive_err = 0;
  int          contention = 0;
  int          hz_left = 0;

  wire act_lo = !mem_ce_n && !mem_we_n && !mem_be_n[0];
  wire act_hi = !mem_ce_n && !mem_we_n && !mem_be_n[1];

  // Storage happens when a lane's write overlap ends (R1, R6).
  always @(negedge act_lo) if (armed) begin
    logic [15:0] t;
    t = mem.exists(mem_addr) ? mem[mem_addr] : 16'h0;
    t[7:0] = mem_dq_out[7:0];
    if (!mem_dq_oe) nodrive_err++;
    mem[mem_addr] = t;
    wr_evt++;
  end
  always @(negedge act_hi) if (armed) begin
    logic [15:0] t;
    t = mem.exists(mem_addr) ? mem[mem_addr] : 16'h0;
    t[15:8] = mem_dq_out[15:8];
    if (!mem_dq_oe) nodrive_err++;
    mem[mem_addr] = t;
    wr_evt++;
  end

  always @(mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_addr, wr_evt) begin
    logic [15:0] v;
    v = mem.exists(mem_addr) ? mem[mem_addr] : 16'h0;
    mem_dq_in[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[0]) ? v[7:0]  : 8'hzz;
    mem_dq_in[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[1]) ? v[15:8] : 8'hzz;
  end

  // Memory may keep driving HZ_CYC cycles after output enable rises (R10).
  always @(negedge clk) if (armed) begin
    if (!mem_ce_n && !mem_oe_n) begin
      if (mem_dq_oe) contention++;
      hz_left = HZ_CYC;
    end else if (hz_left > 0) begin
      if (mem_dq_oe) contention++;
      hz_left--;
    end
  end

  // ---------------- operation task ----------------
  int         o_busy, o_we, o_oe, o_ce, o_drv, o_rv;
  logic [15:0] o_rd;

  task automatic do_op(input logic wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    o_busy = 0; o_we = 0; o_oe = 0; o_ce = 0; o_drv = 0; o_rv = 0; o_rd = 16'hxxxx;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = $urandom_range(1);
    req_addr  = 18'($urandom);
    req_mask  = 2'($urandom);
    while (!req_ready) begin
      o_busy++;
      if (!mem_we_n) o_we++;
      if (!mem_oe_n) o_oe++;
      if (!mem_ce_n) o_ce++;
      if (mem_dq_oe) o_drv++;
      if (rsp_valid) begin o_rv++; o_rd = rsp_rdata; end
      @(negedge clk);
      if (o_busy > 1000) break;
    end
    if (rsp_valid) o_rv++;
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic write_and_check(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    do_op(1'b1, a, d, m);
    if (m == 2'b00) begin
      chk("R9 noop busy cycles", o_busy, 0);
      chk("R9 noop ce_n", {31'b0, mem_ce_n}, 1);
    end else begin
      refm[a] = (refm[a] & ~lane_mask(m)) | (d & lane_mask(m));
      chk("R4 WE low cycles", o_we, E_WE);
      chk("R8 write ready-low cycles", o_busy, E_WR);
      chk("R6 write data driven cycles", o_drv, E_WR);
      chk("R1 chip enable low during write", o_ce, E_WR);
    end
    chk("R7 no response on write", o_rv, 0);
  endtask

  task automatic read_and_check(input logic [17:0] a, input logic [1:0] m);
    do_op(1'b0, a, 16'h0, m);
    if (m == 2'b00) begin
      chk("R9 noop read busy", o_busy, 0);
      chk("R9 noop read response", o_rv, 0);
    end else begin
      chk("R5 OE low cycles", o_oe, E_RD);
      chk("R5 read ready-low cycles", o_busy, E_RD + E_TA);
      chk("R2 no drive during read", o_drv, 0);
      chk("R7 single response", o_rv, 1);
      chk("R2 read data", o_rd, refm[a] & lane_mask(m));
    end
  endtask

  logic [17:0] pool [16];

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 16; i++) begin
      pool[i] = (i == 0) ? 18'h0 : (i == 15) ? 18'h3FFFF : 18'((i * 18'h0B3C5) ^ 18'h15A5A);
      mem[pool[i]]  = 16'($urandom);
      refm[pool[i]] = mem[pool[i]];
    end
    repeat (4) @(negedge clk);
    // R3 reset state
    chk("R3 reset ready", {31'b0, req_ready}, 1);
    chk("R3 reset strobes", {28'b0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    chk("R3 reset lane enables", {30'b0, mem_be_n}, 2'b11);
    chk("R7 reset response", {31'b0, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    armed = 1'b1;

    // Directed corner cases
    write_and_check(18'h0, 16'hA55A, 2'b11);
    read_and_check(18'h0, 2'b11);
    write_and_check(18'h0, 16'h1234, 2'b01);   // R1 lower lane only
    read_and_check(18'h0, 2'b11);
    write_and_check(18'h0, 16'hBEEF, 2'b10);   // R1 upper lane only
    read_and_check(18'h0, 2'b01);              // R2 upper reads zero
    read_and_check(18'h0, 2'b10);
    write_and_check(18'h3FFFF, 16'hC3C3, 2'b00); // R9 no-op write
    read_and_check(18'h3FFFF, 2'b11);
    write_and_check(18'h3FFFF, 16'h0F0F, 2'b11);
    read_and_check(18'h3FFFF, 2'b00);
    read_and_check(18'h3FFFF, 2'b11);
    chk("R3 idle strobes", {28'b0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

    // Constrained random mix, back to back
    for (int k = 0; k < 160; k++) begin
      logic [17:0] a;
      logic [1:0]  m;
      a = pool[$urandom_range(15)];
      m = 2'($urandom);
      if ($urandom_range(1)) write_and_check(a, 16'($urandom), m);
      else                   read_and_check(a, m);
    end
    for (int i = 0; i < 16; i++) read_and_check(pool[i], 2'b11);

    chk("R10 bus contention cycles", contention, 0);
    chk("R6 data held at write end", nodrive_err, 0);
    chk("R8 handshake ready at end", {31'b0, req_ready}, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R8 actual=busy expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule